// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block is the address unit of an 8-bit processor core. The decoder presents the addressing mode of the current instruction. The block also receives the one or two operand bytes that follow the opcode, the two index registers and the address of the opcode. From these it forms the 16-bit address of the operand. For immediate operands it gives the location of the operand bytes inside the instruction stream. For branches it gives the target. Fetching opcodes and operands is done elsewhere.

The arithmetic is combinational. A parameter selects whether the results leave through a pipeline register, which adds one cycle of latency, or pass straight through. There are two absolute forms: a one-byte direct page, zero-extended, and a full 16-bit extended address. Indexed offsets are unsigned bytes. Branch offsets are signed bytes, counted from the address two past the opcode. All address sums wrap modulo 2^16.

Top module: `eff_addr_gen`

## Requirements
- R1: Mode code 1 (direct) drives `eff_addr` to the first operand byte, zero-extended, with `addr_valid`=1 and `is_imm`=0.
- R2: Mode code 2 (extended) drives `eff_addr` to {first byte, second byte}, with the first byte as the high half.
- R3: Mode code 3 (X-indexed) drives `eff_addr` to X plus the first byte taken as unsigned 0..255, modulo 2^16.
- R4: Mode code 4 (Y-indexed) drives `eff_addr` to Y plus the first byte taken as unsigned, modulo 2^16. The X value has no effect.
- R5: Mode code 6 (relative) drives both `eff_addr` and `branch_tgt` to instruction address + 2 + the first byte sign-extended (-128..+127), modulo 2^16. In every other mode `branch_tgt` is 0.
- R6: Mode code 0 (immediate) sets `is_imm`=1 and `eff_addr` = instruction address + 1. `imm_len` is 2 when `imm_wide`=1 and 1 otherwise. In every other mode `is_imm`=0 and `imm_len`=0.
- R7: Mode code 5 (inherent) and the unused code 7 drive `addr_valid`=0 and all other outputs to 0. Operand bytes and registers have no effect.
- R8: With the default `REG_OUT`=1, each output reflects the inputs sampled at the previous rising clock edge. An active-low `rst_n` clears all outputs to 0 asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Addressing mode code (0 imm, 1 direct, 2 extended, 3 X-indexed, 4 Y-indexed, 5 inherent, 6 relative) |
| imm_wide | input | 1 | Immediate operand is two bytes |
| op_b0 | input | 8 | First operand byte after the opcode |
| op_b1 | input | 8 | Second operand byte after the opcode |
| idx_x | input | 16 | Index register X |
| idx_y | input | 16 | Index register Y |
| insn_addr | input | 16 | Address of the opcode byte |
| eff_addr | output | 16 | Effective address or immediate operand location |
| addr_valid | output | 1 | An address is produced |
| is_imm | output | 1 | Operand is immediate |
| imm_len | output | 2 | Immediate operand length in bytes |
| branch_tgt | output | 16 | Branch target in relative mode, else 0 |

## Verification
On every clock cycle, the assertions check how the outputs relate to the inputs sampled one edge earlier. They cover the direct zero page, the extended byte order, the X-indexed sum and the quiet inherent result. They also check that the relative target matches the effective address and that an immediate result carries no branch target.

Only the bench's scenarios can show certain points:
- the exact numeric wrap of indexed and branch sums at the top of memory;
- the sign handling at the offset limits -128 and +127;
- the immediate length choice;
- that the unused mode code stays quiet;
- the one-cycle latency and the asynchronous clearing by reset.

// File: rtl/eag_pkg.sv
package eag_pkg;

   typedef enum logic [2:0] {
      AM_IMM = 3'd0,
      AM_DIR = 3'd1,
      AM_EXT = 3'd2,
      AM_IDX = 3'd3,
      AM_IDY = 3'd4,
      AM_INH = 3'd5,
      AM_REL = 3'd6,
      AM_RSV = 3'd7
   } amode_e;

   typedef enum logic [1:0] {
      BASE_ZERO = 2'd0,
      BASE_PC   = 2'd1,
      BASE_X    = 2'd2,
      BASE_Y    = 2'd3
   } base_sel_e;

   typedef enum logic [1:0] {
      OFF_NONE = 2'd0,
      OFF_ONE  = 2'd1,
      OFF_ZX   = 2'd2,
      OFF_REL  = 2'd3
   } off_sel_e;

   typedef struct packed {
      logic      valid;
      logic      imm;
      logic      rel;
      logic      abs16;
      base_sel_e base;
      off_sel_e  off;
   } ctl_t;

endpackage

// File: rtl/eag_mode_decode.sv
module eag_mode_decode
   import eag_pkg::*;
(
   input  amode_e mode_i,
   output ctl_t   ctl_o
);

   always_comb begin
      ctl_o = '{valid: 1'b0, imm: 1'b0, rel: 1'b0, abs16: 1'b0,
                base: BASE_ZERO, off: OFF_NONE};
      unique case (mode_i)
         AM_IMM: begin
            ctl_o.valid = 1'b1;
            ctl_o.imm   = 1'b1;
            ctl_o.base  = BASE_PC;
            ctl_o.off   = OFF_ONE;
         end
         AM_DIR: begin
            ctl_o.valid = 1'b1;
            ctl_o.off   = OFF_ZX;
         end
         AM_EXT: begin
            ctl_o.valid = 1'b1;
            ctl_o.abs16 = 1'b1;
         end
         AM_IDX: begin
            ctl_o.valid = 1'b1;
            ctl_o.base  = BASE_X;
            ctl_o.off   = OFF_ZX;
         end
         AM_IDY: begin
            ctl_o.valid = 1'b1;
            ctl_o.base  = BASE_Y;
            ctl_o.off   = OFF_ZX;
         end
         AM_REL: begin
            ctl_o.valid = 1'b1;
            ctl_o.rel   = 1'b1;
            ctl_o.base  = BASE_PC;
            ctl_o.off   = OFF_REL;
         end
         AM_INH, AM_RSV: begin
            ctl_o.valid = 1'b0;
         end
         default: begin
            ctl_o.valid = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/eag_addr_adder.sv
module eag_addr_adder
   import eag_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  off_sel_e          off_i,
   output logic [ADDR_W-1:0] sum_o
);

   localparam int PAD_W = ADDR_W - BYTE_W;

   logic [ADDR_W-1:0] zx_off;
   logic [ADDR_W-1:0] sx_off;
   logic [ADDR_W-1:0] off;

   assign zx_off = {{PAD_W{1'b0}}, byte_i};
   assign sx_off = {{PAD_W{byte_i[BYTE_W-1]}}, byte_i};

   always_comb begin
      unique case (off_i)
         OFF_NONE: off = '0;
         OFF_ONE:  off = ADDR_W'(1);
         OFF_ZX:   off = zx_off;
         OFF_REL:  off = sx_off + ADDR_W'(2);
         default:  off = '0;
      endcase
   end

   assign sum_o = base_i + off;

endmodule

// File: rtl/eag_out_stage.sv
module eag_out_stage #(
   parameter int W       = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (REG_OUT) begin : g_reg
         logic [W-1:0] q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= '0;
            else        q_r <= d_i;
         end
         assign q_o = q_r;
      end else begin : g_pass
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign q_o = d_i;
      end
   endgenerate

endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
   import eag_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int ADDR_W  = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode,
   input  logic              imm_wide,
   input  logic [BYTE_W-1:0] op_b0,
   input  logic [BYTE_W-1:0] op_b1,
   input  logic [ADDR_W-1:0] idx_x,
   input  logic [ADDR_W-1:0] idx_y,
   input  logic [ADDR_W-1:0] insn_addr,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              addr_valid,
   output logic              is_imm,
   output logic [1:0]        imm_len,
   output logic [ADDR_W-1:0] branch_tgt
);

   localparam int PAY_W = 2 * ADDR_W + 4;

   generate
      if (ADDR_W != 2 * BYTE_W) begin : g_bad_width
         $error("eff_addr_gen: ADDR_W must equal two operand bytes");
      end
      if (BYTE_W < 2) begin : g_bad_byte
         $error("eff_addr_gen: BYTE_W too small");
      end
   endgenerate

   ctl_t              ctl;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] sum;
   logic [ADDR_W-1:0] eff_c;
   logic [ADDR_W-1:0] br_c;
   logic [1:0]        len_c;
   logic [PAY_W-1:0]  pay_d;
   logic [PAY_W-1:0]  pay_q;

   eag_mode_decode u_dec (
      .mode_i (amode_e'(mode)),
      .ctl_o  (ctl)
   );

   always_comb begin
      unique case (ctl.base)
         BASE_PC:   base = insn_addr;
         BASE_X:    base = idx_x;
         BASE_Y:    base = idx_y;
         default:   base = '0;
      endcase
   end

   eag_addr_adder #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_add (
      .base_i (base),
      .byte_i (op_b0),
      .off_i  (ctl.off),
      .sum_o  (sum)
   );

   always_comb begin
      if (!ctl.valid)     eff_c = '0;
      else if (ctl.abs16) eff_c = {op_b0, op_b1};
      else                eff_c = sum;
   end

   assign br_c  = ctl.rel ? sum : '0;
   assign len_c = !ctl.imm ? 2'd0 : (imm_wide ? 2'd2 : 2'd1);
   assign pay_d = {eff_c, br_c, ctl.valid, ctl.imm, len_c};

   eag_out_stage #(.W(PAY_W), .REG_OUT(REG_OUT)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pay_d),
      .q_o   (pay_q)
   );

   assign {eff_addr, branch_tgt, addr_valid, is_imm, imm_len} = pay_q;

endmodule

// File: rtl/eff_addr_gen_chk.sv
module eff_addr_gen_chk #(
   parameter int BYTE_W  = 8,
   parameter int ADDR_W  = 16,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        mode,
   input logic [BYTE_W-1:0] op_b0,
   input logic [BYTE_W-1:0] op_b1,
   input logic [ADDR_W-1:0] idx_x,
   input logic [ADDR_W-1:0] eff_addr,
   input logic              addr_valid,
   input logic              is_imm,
   input logic [ADDR_W-1:0] branch_tgt
);

   logic              primed;
   logic [2:0]        m_q;
   logic [BYTE_W-1:0] b0_q, b1_q;
   logic [ADDR_W-1:0] x_q;
   logic [2:0]        m_r;
   logic [BYTE_W-1:0] b0_r, b1_r;
   logic [ADDR_W-1:0] x_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   always_ff @(posedge clk) begin
      m_q  <= mode;
      b0_q <= op_b0;
      b1_q <= op_b1;
      x_q  <= idx_x;
   end

   assign m_r  = REG_OUT ? m_q  : mode;
   assign b0_r = REG_OUT ? b0_q : op_b0;
   assign b1_r = REG_OUT ? b1_q : op_b1;
   assign x_r  = REG_OUT ? x_q  : idx_x;

   // R1
   dir_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && m_r == 3'd1) |->
         (addr_valid && eff_addr == {{(ADDR_W-BYTE_W){1'b0}}, b0_r}));

   // R2
   ext_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && m_r == 3'd2) |-> (eff_addr == {b0_r, b1_r}));

   // R3
   idx_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && m_r == 3'd3) |->
         (ADDR_W'(eff_addr - x_r) == {{(ADDR_W-BYTE_W){1'b0}}, b0_r}));

   // R5
   rel_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && m_r == 3'd6) |-> (eff_addr == branch_tgt && addr_valid));

   // R6
   imm_nobranch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_imm |-> (addr_valid && branch_tgt == '0));

   // R7
   inh_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && (m_r == 3'd5 || m_r == 3'd7)) |->
         (!addr_valid && eff_addr == '0 && !is_imm));

endmodule

bind eff_addr_gen eff_addr_gen_chk #(
   .BYTE_W (BYTE_W),
   .ADDR_W (ADDR_W),
   .REG_OUT(REG_OUT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode       (mode),
   .op_b0      (op_b0),
   .op_b1      (op_b1),
   .idx_x      (idx_x),
   .eff_addr   (eff_addr),
   .addr_valid (addr_valid),
   .is_imm     (is_imm),
   .branch_tgt (branch_tgt)
);

// File: tb/eff_addr_gen_test.sv
module eff_addr_gen_test;

   typedef struct packed {
      logic [2:0]  mode;
      logic        wide;
      logic [7:0]  b0;
      logic [7:0]  b1;
      logic [15:0] x;
      logic [15:0] y;
      logic [15:0] pc;
      logic [15:0] e_eff;
      logic        e_val;
      logic        e_imm;
      logic [1:0]  e_len;
      logic [15:0] e_br;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      '{3'd1, 1'b0, 8'hA5, 8'h11, 16'h1234, 16'h5678, 16'h0400, 16'h00A5, 1'b1, 1'b0, 2'd0, 16'h0000},
      '{3'd1, 1'b0, 8'hFF, 8'h00, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h00FF, 1'b1, 1'b0, 2'd0, 16'h0000},
      '{3'd2, 1'b0, 8'h42, 8'h30, 16'h1111, 16'h2222, 16'h0800, 16'h4230, 1'b1, 1'b0, 2'd0, 16'h0000},
      '{3'd2, 1'b1, 8'hFF, 8'hFF, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 1'b1, 1'b0, 2'd0, 16'h0000},
      '{3'd3, 1'b0, 8'h08, 8'h99, 16'h1000, 16'h7777, 16'h0300, 16'h1008, 1'b1, 1'b0, 2'd0, 16'h0000},
      '{3'd3, 1'b0, 8'h20, 8'h00, 16'hFFF0, 16'h0000, 16'h0300, 16'h0010, 1'b1, 1'b0, 2'd0, 16'h0000},
      '{3'd3, 1'b0, 8'hFF, 8'h00, 16'h1234, 16'hAAAA, 16'h0300, 16'h1333, 1'b1, 1'b0, 2'd0, 16'h0000},
      '{3'd4, 1'b0, 8'hFF, 8'h00, 16'h5555, 16'h2000, 16'h0300, 16'h20FF, 1'b1, 1'b0, 2'd0, 16'h0000},
      '{3'd4, 1'b0, 8'h01, 8'h00, 16'h0000, 16'hFFFF, 16'h0300, 16'h0000, 1'b1, 1'b0, 2'd0, 16'h0000},
      '{3'd6, 1'b0, 8'h7F, 8'h00, 16'h0000, 16'h0000, 16'h0100, 16'h0181, 1'b1, 1'b0, 2'd0, 16'h0181},
      '{3'd6, 1'b0, 8'h80, 8'h00, 16'h0000, 16'h0000, 16'h0100, 16'h0082, 1'b1, 1'b0, 2'd0, 16'h0082},
      '{3'd6, 1'b0, 8'h00, 8'h00, 16'h0000, 16'h0000, 16'hFFFE, 16'h0000, 1'b1, 1'b0, 2'd0, 16'h0000},
      '{3'd6, 1'b0, 8'hF0, 8'h00, 16'h0000, 16'h0000, 16'h0005, 16'hFFF7, 1'b1, 1'b0, 2'd0, 16'hFFF7},
      '{3'd0, 1'b0, 8'h33, 8'h44, 16'h0000, 16'h0000, 16'h2000, 16'h2001, 1'b1, 1'b1, 2'd1, 16'h0000},
      '{3'd0, 1'b1, 8'h33, 8'h44, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 1'b1, 1'b1, 2'd2, 16'h0000},
      '{3'd5, 1'b1, 8'h12, 8'h34, 16'hABCD, 16'hDCBA, 16'h0777, 16'h0000, 1'b0, 1'b0, 2'd0, 16'h0000},
      '{3'd7, 1'b1, 8'h56, 8'h78, 16'h9999, 16'h8888, 16'h1234, 16'h0000, 1'b0, 1'b0, 2'd0, 16'h0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode = '0;
   logic        imm_wide = 1'b0;
   logic [7:0]  op_b0 = '0;
   logic [7:0]  op_b1 = '0;
   logic [15:0] idx_x = '0;
   logic [15:0] idx_y = '0;
   logic [15:0] insn_addr = '0;
   logic [15:0] eff_addr;
   logic        addr_valid;
   logic        is_imm;
   logic [1:0]  imm_len;
   logic [15:0] branch_tgt;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   eff_addr_gen uut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .imm_wide(imm_wide),
      .op_b0(op_b0), .op_b1(op_b1), .idx_x(idx_x), .idx_y(idx_y),
      .insn_addr(insn_addr), .eff_addr(eff_addr), .addr_valid(addr_valid),
      .is_imm(is_imm), .imm_len(imm_len), .branch_tgt(branch_tgt)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req, input vec_t v);
      chk(req, "eff_addr",   32'(eff_addr),   32'(v.e_eff));
      chk(req, "addr_valid", 32'(addr_valid), 32'(v.e_val));
      chk(req, "is_imm",     32'(is_imm),     32'(v.e_imm));
      chk(req, "imm_len",    32'(imm_len),    32'(v.e_len));
      chk(req, "branch_tgt", 32'(branch_tgt), 32'(v.e_br));
   endtask

   function automatic string req_of(input logic [2:0] m);
      case (m)
         3'd0: return "R6";
         3'd1: return "R1";
         3'd2: return "R2";
         3'd3: return "R3";
         3'd4: return "R4";
         3'd6: return "R5";
         default: return "R7";
      endcase
   endfunction

   task automatic drive(input vec_t v);
      mode = v.mode; imm_wide = v.wide; op_b0 = v.b0; op_b1 = v.b1;
      idx_x = v.x; idx_y = v.y; insn_addr = v.pc;
   endtask

   initial begin
      vec_t zero_v;
      vec_t probe;
      zero_v = '0;
      // R8 reset state
      mode = 3'd2; op_b0 = 8'hDE; op_b1 = 8'hAD;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_all("R8", zero_v);
      rst_n = 1'b1;

      // vector table: all modes
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i]);
         @(posedge clk);
         @(negedge clk);
         chk_all(req_of(VEC[i].mode), VEC[i]);
      end

      // R8 latency: output holds last result until the next edge
      @(negedge clk);
      probe = '{3'd2, 1'b0, 8'hBE, 8'hEF, 16'h0, 16'h0, 16'h0,
                16'hBEEF, 1'b1, 1'b0, 2'd0, 16'h0};
      drive(probe);
      #1;
      chk("R8", "eff before edge", 32'(eff_addr), 32'h0);
      @(posedge clk);
      @(negedge clk);
      chk("R8", "eff after edge", 32'(eff_addr), 32'hBEEF);

      // R8 asynchronous clear, no clock edge needed
      #1 rst_n = 1'b0;
      #0.5;
      chk_all("R8", zero_v);
      @(negedge clk);
      rst_n = 1'b1;

      // R4 X must not influence Y-indexed result
      probe = '{3'd4, 1'b0, 8'h10, 8'h00, 16'hFFFF, 16'h0100, 16'h0,
                16'h0110, 1'b1, 1'b0, 2'd0, 16'h0};
      drive(probe);
      @(posedge clk);
      @(negedge clk);
      chk_all("R4", probe);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule